// File: doc/BRIEF.md
# Address Bus Grant Qualifier

This block sits in a bus master and decides the exact cycle in which the master may take the shared address bus. The arbiter's grant alone is not enough. The master also watches the bus for a transfer start, an address acknowledge and an address retry, and it takes the bus only in a cycle where none of the three is active. It also honours a blackout after any retry is seen on the bus.

The block tracks its own address tenure from the take strobe until the acknowledge arrives. It then checks the single cycle after that acknowledge. A retry in that cycle sends the tenure back to the request stage. When this master itself drives a retry because a snoop hit a modified line, it asks for the bus in the very next cycle. It then takes the bus for the line push at its first qualified grant, ahead of any ordinary transfer it has queued.

Top module: `abus_grant_qual`

## Requirements
- R1: `take_own` is high only in a cycle where `bus_req`, `bus_grant` are high and `xfer_start`, `addr_ack`, `addr_retry` are all low; a grant without a request is never taken.
- R2: The cycle after the acknowledge of this master's own tenure is its retry window. `addr_retry` high there makes `bus_req` high in the following cycle so the tenure is re-requested. `addr_retry` low there completes the tenure with no new request.
- R3: If `addr_retry` is high in cycle t, `take_own` stays low in cycles t and t+1.
- R4: `self_retry` high in cycle t (this master drives a retry for a modified-line hit) makes `bus_req` high in cycle t+1.
- R5: An owed line push is taken at the first qualified grant, with `own_push` high together with `take_own`. It takes precedence over a queued ordinary transfer.
- R6: Once high, `bus_req` stays high until `take_own`. After an ordinary take, `bus_req` in the next cycle equals `xfer_more`. After a push take, an ordinary transfer latched from `xfer_pending` keeps `bus_req` high.
- R7: `take_own` is a one-cycle pulse. It is never high between a take and the acknowledge of that tenure.
- R8: Synchronous reset `rst` clears all state. `take_own` is low while `rst` is high, and `bus_req` is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_grant | input | 1 | Address bus grant from the arbiter |
| xfer_start | input | 1 | Transfer start seen on the bus |
| addr_ack | input | 1 | Address acknowledge seen on the bus |
| addr_retry | input | 1 | Address retry seen on the bus |
| self_retry | input | 1 | This master is driving a retry because of a modified-line hit |
| xfer_pending | input | 1 | An ordinary transfer is queued (latched until taken) |
| xfer_more | input | 1 | Another ordinary transfer waits behind the one being taken |
| bus_req | output | 1 | Address bus request |
| take_own | output | 1 | One-cycle strobe: the address tenure starts this cycle |
| own_push | output | 1 | The tenure started by `take_own` is a line push |

## Verification
`take_own` and `own_push` are combinational. They are due in the same cycle as the bus inputs that qualify them. `bus_req` is registered, so it answers `xfer_pending`, `self_retry`, a window retry or a take one cycle later. The retry blackout reaches one cycle past the retry. Each driver step pushes the expected values for the cycle it drives. The monitor compares them in that same cycle, after the inputs settle and before the next rising edge, so every registered result is checked exactly one step after its cause.

// File: rtl/abgq_pkg.sv
package abgq_pkg;

    typedef enum logic [1:0] {
        TEN_IDLE     = 2'd0,
        TEN_WAIT_ACK = 2'd1,
        TEN_WINDOW   = 2'd2
    } tenure_st_e;

    typedef struct packed {
        logic grant;
        logic ts;
        logic aack;
        logic artry;
    } bus_obs_t;

    // No address-phase activity on the bus this cycle.
    function automatic logic bus_quiet(input bus_obs_t o);
        return !o.ts && !o.aack && !o.artry;
    endfunction

endpackage

// File: rtl/abgq_retry_watch.sv
module abgq_retry_watch (
    input  logic clk,
    input  logic rst,
    input  logic addr_retry,
    output logic blackout
);
    // A retry seen in one cycle keeps the grant blocked for one more cycle.
    always_ff @(posedge clk) begin
        if (rst) blackout <= 1'b0;
        else     blackout <= addr_retry;
    end
endmodule

// File: rtl/abgq_tenure_fsm.sv
module abgq_tenure_fsm
    import abgq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic take_push,
    input  logic addr_ack,
    input  logic addr_retry,
    output logic busy,
    output logic retried,
    output logic retried_push
);
    tenure_st_e st;
    logic       cur_push;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= TEN_IDLE;
            cur_push <= 1'b0;
        end else begin
            unique case (st)
                TEN_IDLE:     if (take) st <= TEN_WAIT_ACK;
                TEN_WAIT_ACK: if (addr_ack) st <= TEN_WINDOW;
                TEN_WINDOW:   st <= take ? TEN_WAIT_ACK : TEN_IDLE;
                default:      st <= TEN_IDLE;
            endcase
            if (take) cur_push <= take_push;
        end
    end

    assign busy         = (st == TEN_WAIT_ACK);
    assign retried      = (st == TEN_WINDOW) && addr_retry;
    assign retried_push = retried && cur_push;
endmodule

// File: rtl/abgq_req_ctrl.sv
module abgq_req_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic self_retry,
    input  logic xfer_pending,
    input  logic xfer_more,
    input  logic take,
    input  logic take_push,
    input  logic retried,
    input  logic retried_push,
    output logic push_owed,
    output logic bus_req
);
    logic norm_owed;
    logic take_norm;

    assign take_norm = take && !take_push;

    always_ff @(posedge clk) begin
        if (rst) begin
            push_owed <= 1'b0;
            norm_owed <= 1'b0;
        end else begin
            push_owed <= (push_owed && !(take && take_push)) || self_retry || retried_push;
            norm_owed <= (take_norm ? xfer_more : (norm_owed || xfer_pending))
                         || (retried && !retried_push);
        end
    end

    assign bus_req = push_owed || norm_owed;

    // R2: a retried tenure is requested again in the next cycle
    a_r2_rereq: assert property (@(posedge clk) disable iff (rst)
        retried |=> bus_req);
endmodule

// File: rtl/abus_grant_qual.sv
module abus_grant_qual
    import abgq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bus_grant,
    input  logic xfer_start,
    input  logic addr_ack,
    input  logic addr_retry,
    input  logic self_retry,
    input  logic xfer_pending,
    input  logic xfer_more,
    output logic bus_req,
    output logic take_own,
    output logic own_push
);
    bus_obs_t obs;
    logic     blackout;
    logic     busy;
    logic     retried;
    logic     retried_push;
    logic     push_owed;

    assign obs = '{grant: bus_grant, ts: xfer_start, aack: addr_ack, artry: addr_retry};

    abgq_retry_watch u_watch (
        .clk        (clk),
        .rst        (rst),
        .addr_retry (addr_retry),
        .blackout   (blackout)
    );

    abgq_tenure_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .take         (take_own),
        .take_push    (own_push),
        .addr_ack     (addr_ack),
        .addr_retry   (addr_retry),
        .busy         (busy),
        .retried      (retried),
        .retried_push (retried_push)
    );

    abgq_req_ctrl u_req (
        .clk          (clk),
        .rst          (rst),
        .self_retry   (self_retry),
        .xfer_pending (xfer_pending),
        .xfer_more    (xfer_more),
        .take         (take_own),
        .take_push    (own_push),
        .retried      (retried),
        .retried_push (retried_push),
        .push_owed    (push_owed),
        .bus_req      (bus_req)
    );

    assign take_own = !rst && bus_req && obs.grant && bus_quiet(obs) && !blackout && !busy;
    assign own_push = take_own && push_owed;

    // R3: no take in the cycle after a retry
    a_r3_blackout: assert property (@(posedge clk) disable iff (rst)
        addr_retry |=> !take_own);

    // R4: a self-driven retry raises the request next cycle
    a_r4_push_req: assert property (@(posedge clk) disable iff (rst)
        self_retry |=> bus_req);

    // R6: the request is held until mastership is taken
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !take_own) |=> bus_req);

    // R7: the strobe lasts one cycle
    a_r7_pulse: assert property (@(posedge clk) disable iff (rst)
        take_own |=> !take_own);

    // R8: reset clears the request
    a_r8_reset: assert property (@(posedge clk)
        rst |=> !bus_req);

    // R8: no strobe during reset
    always_comb begin
        if (rst) a_r8_no_take: assert (!take_own);
    end
endmodule

// File: tb/abus_grant_qual_bench.sv
module abus_grant_qual_bench;
    logic clk = 1'b0;
    logic rst, bus_grant, xfer_start, addr_ack, addr_retry;
    logic self_retry, xfer_pending, xfer_more;
    logic bus_req, take_own, own_push;

    always #5 clk = ~clk;

    abus_grant_qual u_abus_grant_qual (
        .clk(clk), .rst(rst), .bus_grant(bus_grant), .xfer_start(xfer_start),
        .addr_ack(addr_ack), .addr_retry(addr_retry), .self_retry(self_retry),
        .xfer_pending(xfer_pending), .xfer_more(xfer_more),
        .bus_req(bus_req), .take_own(take_own), .own_push(own_push)
    );

    typedef struct {
        logic  req;
        logic  take;
        logic  push;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   errors = 0;
    int   checks = 0;
    bit   done   = 1'b0;

    // Driver: one call = one cycle of inputs plus the outputs expected in it.
    task automatic cyc(input logic r, input logic g, input logic ts, input logic ak,
                       input logic rt, input logic sr, input logic xp, input logic xm,
                       input logic e_req, input logic e_take, input logic e_push,
                       input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; bus_grant = g; xfer_start = ts; addr_ack = ak; addr_retry = rt;
        self_retry = sr; xfer_pending = xp; xfer_more = xm;
        e.req = e_req; e.take = e_take; e.push = e_push; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compares in the middle of the low phase.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (bus_req !== e.req || take_own !== e.take || own_push !== e.push) begin
                    errors++;
                    $display("FAIL %s: req/take/push actual=%b%b%b expected=%b%b%b",
                             e.tag, bus_req, take_own, own_push, e.req, e.take, e.push);
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        //   rst g ts ak rt sr xp xm   req take push
        // R8: reset holds everything low even with grant and work queued
        cyc(1, 1, 0, 0, 0, 0, 1, 0,   1'bx, 0, 0, "R8");
        exp_q.delete();
        cyc(1, 1, 0, 0, 0, 0, 1, 0,   0, 0, 0, "R8");
        cyc(0, 1, 0, 0, 0, 0, 0, 0,   0, 0, 0, "R8");
        // Scenario A: plain request, take, clean window (R1 R6 R2)
        cyc(0, 0, 0, 0, 0, 0, 1, 0,   0, 0, 0, "R1");
        cyc(0, 0, 0, 0, 0, 0, 0, 0,   1, 0, 0, "R6");
        cyc(0, 1, 0, 0, 0, 0, 0, 0,   1, 1, 0, "R1");
        cyc(0, 1, 0, 0, 0, 0, 0, 0,   0, 0, 0, "R6");
        cyc(0, 0, 0, 1, 0, 0, 0, 0,   0, 0, 0, "R7");
        cyc(0, 0, 0, 0, 0, 0, 0, 0,   0, 0, 0, "R2");
        cyc(0, 0, 0, 0, 0, 0, 0, 0,   0, 0, 0, "R2");
        // Scenario B: bus activity blocks the grant, blackout, busy, window retry
        cyc(0, 0, 0, 0, 0, 0, 1, 0,   0, 0, 0, "R6");
        cyc(0, 1, 1, 0, 0, 0, 0, 0,   1, 0, 0, "R1");
        cyc(0, 1, 0, 1, 0, 0, 0, 0,   1, 0, 0, "R1");
        cyc(0, 1, 0, 0, 1, 0, 0, 0,   1, 0, 0, "R3");
        cyc(0, 1, 0, 0, 0, 0, 0, 0,   1, 0, 0, "R3");
        cyc(0, 1, 0, 0, 0, 0, 0, 1,   1, 1, 0, "R1");
        cyc(0, 1, 0, 0, 0, 0, 0, 0,   1, 0, 0, "R7");
        cyc(0, 0, 0, 1, 0, 0, 0, 0,   1, 0, 0, "R7");
        cyc(0, 1, 0, 0, 0, 0, 0, 0,   1, 1, 0, "R6");
        cyc(0, 0, 0, 1, 0, 0, 0, 0,   0, 0, 0, "R6");
        cyc(0, 0, 0, 0, 1, 0, 0, 0,   0, 0, 0, "R2");
        cyc(0, 1, 0, 0, 0, 0, 0, 0,   1, 0, 0, "R2");
        cyc(0, 1, 0, 0, 0, 0, 0, 0,   1, 1, 0, "R2");
        cyc(0, 0, 0, 1, 0, 0, 0, 0,   0, 0, 0, "R6");
        cyc(0, 0, 0, 0, 0, 0, 0, 0,   0, 0, 0, "R2");
        cyc(0, 0, 0, 0, 0, 0, 0, 0,   0, 0, 0, "R2");
        // Scenario C: self retry, push ahead of queued normal transfer
        cyc(0, 0, 0, 0, 1, 1, 1, 0,   0, 0, 0, "R4");
        cyc(0, 1, 0, 0, 0, 0, 0, 0,   1, 0, 0, "R4");
        cyc(0, 1, 0, 0, 0, 0, 0, 0,   1, 1, 1, "R5");
        cyc(0, 0, 0, 1, 0, 0, 0, 0,   1, 0, 0, "R6");
        cyc(0, 1, 0, 0, 0, 0, 0, 0,   1, 1, 0, "R5");
        cyc(0, 0, 0, 1, 0, 0, 0, 0,   0, 0, 0, "R6");
        cyc(0, 0, 0, 0, 0, 0, 0, 0,   0, 0, 0, "R2");
        cyc(0, 1, 0, 0, 0, 0, 0, 0,   0, 0, 0, "R1");
        // Scenario D: reset while a request is up
        cyc(0, 0, 0, 0, 0, 0, 1, 0,   0, 0, 0, "R6");
        cyc(1, 1, 0, 0, 0, 0, 0, 0,   1, 0, 0, "R8");
        cyc(0, 1, 0, 0, 0, 0, 0, 0,   0, 0, 0, "R8");
        cyc(0, 1, 0, 0, 0, 0, 0, 0,   0, 0, 0, "R8");
        @(negedge clk);
        #4;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule